// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches a bus on which each transaction is reduced to two single-clock pulses: one when a cycle begins and one when it completes. When the timer is enabled, a cycle that is still open after a selectable limit is declared hung. The block then emits a one-clock bus-error pulse and sets a sticky status flag. An interrupt output follows that flag while interrupts are enabled. Software clears the flag by writing a one to its bit.

The same control word also gates a separate system-fail output. That output latches when an external watchdog-expired input fires, but only while its enable bit is set. It stays high until the enable is written back to zero or the block is reset.

Timing runs on a microsecond tick derived from the clock by a prescaler, so each timeout limit is a count of ticks. Control is a single 32-bit word. A write updates every field at once, and reads are combinational.

Top module: `bus_tmo_monitor`

## Requirements
- R1: After reset every control field is zero, the read word is 0, and busErr, errIrq and sysFail are low.
- R2: Bit 3 (timer enable), bits 5:4 (limit select), bit 6 (interrupt enable) and bit 8 (system-fail enable) read back as last written. Bit 7 reads the error status. Every other bit reads zero.
- R3: With bit 3 set, a cycStart sampled at edge E opens a cycle. If no cycDone arrives, busErr is high for exactly the one clock after edge E + N*CLKS_PER_US. N is 16, 64, 256 or 1000 for select codes 00, 01, 10 and 11.
- R4: A cycDone sampled before the limit closes the cycle, and no busErr or status follows.
- R5: With bit 3 clear, cycStart is ignored: no busErr and no status.
- R6: The status flag sets on the same edge as busErr and stays set through further errors.
- R7: Writing 1 to bit 7 clears the status and writing 0 leaves it unchanged. If an expiry lands on the same edge as the clearing write, the flag stays set.
- R8: errIrq is high exactly while the status is set and bit 6 is 1.
- R9: With bit 8 set, a wdogExpired pulse latches sysFail high, and it stays high after the input drops. Writing bit 8 to 0 clears it. With bit 8 clear, wdogExpired has no effect.
- R10: A cycStart during an open cycle restarts the full limit from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the control word |
| regWrData | input | 32 | Control word write data |
| regRdData | output | 32 | Control word read data |
| cycStart | input | 1 | Pulse: a bus cycle begins |
| cycDone | input | 1 | Pulse: the bus cycle completed |
| wdogExpired | input | 1 | External watchdog expiry |
| busErr | output | 1 | One-clock pulse on a cycle timeout |
| errIrq | output | 1 | Interrupt request |
| sysFail | output | 1 | Latched system-fail output |

## Verification
The hardest case to reach from the ports is a clearing write to bit 7 that lands on the very edge where an open cycle expires. The bench opens a cycle and counts exactly N*CLKS_PER_US - 1 edges. It then drives the write so that the next edge samples it, and checks that the flag is still set. The restart case uses the same edge counting. A second start lands mid-cycle, and the bench confirms that no pulse appears at the first cycle's deadline and that the pulse arrives exactly one limit after the restart.

// File: rtl/bus_tmo_pkg.sv
package bus_tmo_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned BIT_TIMER_EN = 3;
  localparam int unsigned BIT_SEL_LO   = 4;
  localparam int unsigned BIT_SEL_HI   = 5;
  localparam int unsigned BIT_IRQ_EN   = 6;
  localparam int unsigned BIT_STATUS   = 7;
  localparam int unsigned BIT_SF_EN    = 8;

  typedef struct packed {
    logic       timerOn;
    logic [1:0] limitSel;
    logic       startStb;
    logic       stopStb;
  } tmoCtl_t;
endpackage

// File: rtl/bus_tmo_datapath.sv
module bus_tmo_datapath
  import bus_tmo_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 4,
  parameter int unsigned LIM_0 = 16,
  parameter int unsigned LIM_1 = 64,
  parameter int unsigned LIM_2 = 256,
  parameter int unsigned LIM_3 = 1000
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmoCtl_t ctl,
  output logic    expireNow,
  output logic    busErr
);
  localparam int unsigned MAX_01 = (LIM_0 > LIM_1) ? LIM_0 : LIM_1;
  localparam int unsigned MAX_23 = (LIM_2 > LIM_3) ? LIM_2 : LIM_3;
  localparam int unsigned LIM_MAX = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
  localparam int unsigned US_W = $clog2(LIM_MAX + 1);

  logic            active;
  logic            tick;
  logic [US_W-1:0] usCnt;
  logic [US_W-1:0] limitLast;
  logic            busErrQ;

  generate
    if (CLKS_PER_US <= 1) begin : g_noPrescale
      assign tick = active;
    end else begin : g_prescale
      localparam int unsigned PRE_W = $clog2(CLKS_PER_US);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !active || ctl.startStb) begin
          preCnt <= '0;
        end else if (preCnt == PRE_W'(CLKS_PER_US - 1)) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
      assign tick = active && (preCnt == PRE_W'(CLKS_PER_US - 1));
    end
  endgenerate

  always_comb begin
    unique case (ctl.limitSel)
      2'd0:    limitLast = US_W'(LIM_0 - 1);
      2'd1:    limitLast = US_W'(LIM_1 - 1);
      2'd2:    limitLast = US_W'(LIM_2 - 1);
      default: limitLast = US_W'(LIM_3 - 1);
    endcase
  end

  assign expireNow = active && ctl.timerOn && !ctl.stopStb && !ctl.startStb
                     && tick && (usCnt == limitLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      usCnt   <= '0;
      busErrQ <= 1'b0;
    end else begin
      busErrQ <= expireNow;
      if (!ctl.timerOn || ctl.stopStb) begin
        active <= 1'b0;
      end else if (ctl.startStb) begin
        active <= 1'b1;
        usCnt  <= '0;
      end else if (expireNow) begin
        active <= 1'b0;
      end else if (tick) begin
        usCnt <= usCnt + 1'b1;
      end
    end
  end

  assign busErr = busErrQ;

  // R3: an error is a single-clock pulse
  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !busErr);
  // R4: a completed cycle never yields an error on the next clock
  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stopStb |=> !busErr);
  // R5: a disabled timer produces no errors
  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.timerOn |=> !busErr);
endmodule

// File: rtl/bus_tmo_ctrl.sv
module bus_tmo_ctrl
  import bus_tmo_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             cycStart,
  input  logic             cycDone,
  input  logic             wdogExpired,
  input  logic             expireNow,
  input  logic             busErr,
  output tmoCtl_t          ctl,
  output logic             errIrq,
  output logic             sysFail
);
  logic       timerOnQ;
  logic [1:0] selQ;
  logic       irqEnQ;
  logic       sfEnQ;
  logic       statusQ;
  logic       sysFailQ;
  logic       sfEnNext;
  logic       unusedWrBits;

  assign unusedWrBits = ^{regWrData[REG_W-1:BIT_SF_EN+1], regWrData[BIT_TIMER_EN-1:0]};
  assign sfEnNext = regWrEn ? regWrData[BIT_SF_EN] : sfEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerOnQ <= 1'b0;
      selQ     <= 2'b00;
      irqEnQ   <= 1'b0;
      sfEnQ    <= 1'b0;
      statusQ  <= 1'b0;
      sysFailQ <= 1'b0;
    end else begin
      if (regWrEn) begin
        timerOnQ <= regWrData[BIT_TIMER_EN];
        selQ     <= regWrData[BIT_SEL_HI:BIT_SEL_LO];
        irqEnQ   <= regWrData[BIT_IRQ_EN];
        sfEnQ    <= regWrData[BIT_SF_EN];
      end
      if (expireNow) begin
        statusQ <= 1'b1;
      end else if (regWrEn && regWrData[BIT_STATUS]) begin
        statusQ <= 1'b0;
      end
      sysFailQ <= sfEnNext && (sysFailQ || wdogExpired);
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[BIT_TIMER_EN]           = timerOnQ;
    regRdData[BIT_SEL_HI:BIT_SEL_LO]  = selQ;
    regRdData[BIT_IRQ_EN]             = irqEnQ;
    regRdData[BIT_STATUS]             = statusQ;
    regRdData[BIT_SF_EN]              = sfEnQ;
  end

  always_comb begin
    ctl.timerOn  = timerOnQ;
    ctl.limitSel = selQ;
    ctl.startStb = cycStart && timerOnQ;
    ctl.stopStb  = cycDone;
  end

  assign errIrq  = statusQ && irqEnQ;
  assign sysFail = sysFailQ;

  // R6: the status flag only rises together with an error pulse
  assert_status_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ) |-> busErr);
  // R9: system-fail only latches after an expiry input
  assert_sf_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysFailQ) |-> $past(wdogExpired));
  // R9: system-fail is never high while its enable is clear
  assert_sf_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sfEnQ |-> !sysFailQ);
endmodule

// File: rtl/bus_tmo_monitor.sv
module bus_tmo_monitor
  import bus_tmo_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 4,
  parameter int unsigned LIM_0 = 16,
  parameter int unsigned LIM_1 = 64,
  parameter int unsigned LIM_2 = 256,
  parameter int unsigned LIM_3 = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        cycStart,
  input  logic        cycDone,
  input  logic        wdogExpired,
  output logic        busErr,
  output logic        errIrq,
  output logic        sysFail
);
  tmoCtl_t ctl;
  logic    expireNow;

  bus_tmo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cycStart(cycStart), .cycDone(cycDone),
    .wdogExpired(wdogExpired), .expireNow(expireNow), .busErr(busErr),
    .ctl(ctl), .errIrq(errIrq), .sysFail(sysFail)
  );

  bus_tmo_datapath #(
    .CLKS_PER_US(CLKS_PER_US), .LIM_0(LIM_0), .LIM_1(LIM_1),
    .LIM_2(LIM_2), .LIM_3(LIM_3)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .expireNow(expireNow), .busErr(busErr)
  );
endmodule

// File: tb/sim_bus_tmo_monitor.sv
`timescale 1ns/1ps
module sim_bus_tmo_monitor;
  localparam int DIV = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic cycStart = 1'b0, cycDone = 1'b0, wdogExpired = 1'b0;
  logic busErr, errIrq, sysFail;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_tmo_monitor u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cycStart(cycStart), .cycDone(cycDone),
    .wdogExpired(wdogExpired), .busErr(busErr), .errIrq(errIrq), .sysFail(sysFail)
  );

  function automatic int limitOf(input int sel);
    case (sel)
      0: return 16 * DIV;
      1: return 64 * DIV;
      2: return 256 * DIV;
      default: return 1000 * DIV;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulseStart();
    @(negedge clk); cycStart = 1'b1;
    @(negedge clk); cycStart = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); cycDone = 1'b1;
    @(negedge clk); cycDone = 1'b0;
  endtask

  task automatic watch(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (busErr) hits++;
    end
  endtask

  task automatic testReset();
    chk("R1 readback", regRdData, 32'h0);
    chk("R1 outputs", {29'h0, busErr, errIrq, sysFail}, 32'h0);
  endtask

  task automatic testReadback();
    wr(32'hFFFF_FF7F);
    chk("R2 all ones", regRdData, 32'h0000_0178);
    wr(32'h0000_0000);
    chk("R2 zeros", regRdData, 32'h0);
  endtask

  task automatic testLimit(input int sel);
    int hits;
    int lim = limitOf(sel);
    logic [31:0] cfg = 32'h8 | (32'(sel) << 4);
    wr(cfg);
    pulseStart();
    watch(lim - 1, hits);
    chk("R3 no early error", 32'(hits), 32'd0);
    @(posedge clk); #1;
    chk("R3 error on time", {31'h0, busErr}, 32'd1);
    chk("R6 status with error", {31'h0, regRdData[7]}, 32'd1);
    @(posedge clk); #1;
    chk("R3 single pulse", {31'h0, busErr}, 32'd0);
    wr(cfg | 32'h80);
    chk("R7 cleared", {31'h0, regRdData[7]}, 32'd0);
  endtask

  task automatic testDone();
    int hits;
    wr(32'h8);
    pulseStart();
    watch(20, hits);
    pulseDone();
    watch(limitOf(0) + 10, hits);
    chk("R4 no error after done", 32'(hits), 32'd0);
    chk("R4 no status", {31'h0, regRdData[7]}, 32'd0);
  endtask

  task automatic testDisabled();
    int hits;
    wr(32'h0);
    pulseStart();
    watch(limitOf(0) + 10, hits);
    chk("R5 ignored start", {hits[30:0], regRdData[7]}, 32'd0);
  endtask

  task automatic testStickyIrq();
    int hits;
    wr(32'h48);
    pulseStart();
    watch(limitOf(0) + 2, hits);
    chk("R8 irq on", {31'h0, errIrq}, 32'd1);
    pulseStart();
    watch(limitOf(0) + 2, hits);
    chk("R6 second error seen", 32'(hits), 32'd1);
    chk("R6 still set", {31'h0, regRdData[7]}, 32'd1);
    wr(32'h08);
    chk("R8 irq masked", {30'h0, errIrq, regRdData[7]}, 32'd1);
    wr(32'h48);
    chk("R7 write 0 keeps status", {31'h0, regRdData[7]}, 32'd1);
    chk("R8 irq back", {31'h0, errIrq}, 32'd1);
    wr(32'hC8);
    chk("R7 w1c", {30'h0, errIrq, regRdData[7]}, 32'd0);
  endtask

  task automatic testSameEdge();
    wr(32'h8);
    pulseStart();
    repeat (limitOf(0) - 1) @(posedge clk);
    wr(32'h88);
    chk("R7 set wins", {30'h0, busErr, regRdData[7]}, 32'd3);
    wr(32'h88);
    chk("R7 later clear", {31'h0, regRdData[7]}, 32'd0);
  endtask

  task automatic testRestart();
    int hits;
    wr(32'h8);
    pulseStart();
    repeat (30) @(posedge clk);
    pulseStart();
    watch(limitOf(0) - 1, hits);
    chk("R10 no error at old deadline", 32'(hits), 32'd0);
    @(posedge clk); #1;
    chk("R10 error after restart", {31'h0, busErr}, 32'd1);
    wr(32'h88);
  endtask

  task automatic testSysFail();
    wr(32'h0);
    @(negedge clk); wdogExpired = 1'b1;
    @(negedge clk); wdogExpired = 1'b0;
    chk("R9 ignored when off", {31'h0, sysFail}, 32'd0);
    wr(32'h100);
    @(negedge clk); wdogExpired = 1'b1;
    @(negedge clk); wdogExpired = 1'b0;
    chk("R9 latched", {31'h0, sysFail}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R9 held", {31'h0, sysFail}, 32'd1);
    wr(32'h0);
    chk("R9 cleared by enable", {31'h0, sysFail}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    for (int s = 0; s < 4; s++) testLimit(s);
    testDone();
    testDisabled();
    testStickyIrq();
    testSameEdge();
    testRestart();
    testSysFail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule